// File: doc/BRIEF.md
# Serial Control Bus Peripheral Port

This block is the peripheral end of a four-wire serial control link: an active-low select, a serial clock, a command-data input and a reply-data output with its own output enable for an external tri-state pad. All four serial signals are brought into a faster system clock domain through two-flop synchronisers, and their edges are found there.

Each transaction starts with an address byte. The top two address bits, and bit 0 for reads, decide what follows: no data, one data byte, two data bytes, or a one- or two-byte reply. Received data is held until the select line is released, and only then is a single write strobe issued towards the register file. A read asks the register file for its word as soon as the address byte is complete. The word is then shifted out on falling serial clock edges. The serial clock may idle either high or low.

Top module: `sbus_periph`

## Requirements
- R1: Address and data bits are taken on rising serial clock edges, most significant bit first; a two-byte write presents the first data byte as reg_wdata_o[15:8].
- R2: The write strobe reg_wr_o pulses for exactly one system clock, only after the select line has returned high, never while it is still low.
- R3: Address bits [7:6] select the write length: 00 means no data (reg_wdata_o = 0), 01 means one byte (in reg_wdata_o[7:0], upper bits zero), 10 means two bytes; reg_addr_o shows the address byte.
- R4: If the select line rises before all bits that the address calls for have arrived, no write strobe is issued.
- R5: Addresses with bits [7:6] = 11 are reads: bit 0 = 1 returns all 16 bits of reg_rdata_i, bit 0 = 0 returns reg_rdata_i[7:0]; reply bits go out most significant bit first, one per falling serial clock edge after the address byte.
- R6: Transfers behave the same whether the serial clock idles high or low.
- R7: reply_oe_o is low while the select line is high and stays low after the select falls until the first falling serial clock edge.
- R8: A read address gives one reg_rd_o pulse and no write strobe.
- R9: Serial bits beyond the length the address calls for are ignored and do not change the written data.
- R10: After reset reg_wr_o, reg_rd_o, reply_o and reply_oe_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock, either idle polarity |
| cmd_i | input | 1 | Serial command and data in |
| reply_o | output | 1 | Serial reply data out |
| reply_oe_o | output | 1 | Enable for the reply pad driver |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_rd_o | output | 1 | One-cycle register read request |
| reg_addr_o | output | 8 | Address byte of the current or last transaction |
| reg_wdata_o | output | 16 | Write data, valid with reg_wr_o |
| reg_rdata_i | input | 16 | Read data from the register file for reg_addr_o |

## Verification
Each address class is exercised: no-data, one-byte and two-byte writes, plus both read widths. The data patterns are asymmetric, so a reversed bit order or a swapped byte produces a different word. A transfer that is held open after its last bit tells a commit on select release apart from a commit on the final bit. A truncated write tells length checking apart from committing whatever has arrived. An over-long write shows whether the bit counter stops at the decoded length. The same writes and reads are repeated with the serial clock idling high and idling low, and the reply enable is watched across the gap between the select falling and the first clock low phase.

// File: rtl/sbus_pkg.sv
`timescale 1ns/1ps
package sbus_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 16;
    localparam int MAX_BITS = ADDR_W + DATA_W;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);

    typedef enum logic [2:0] {
        K_W0  = 3'd0,
        K_W8  = 3'd1,
        K_W16 = 3'd2,
        K_R8  = 3'd3,
        K_R16 = 3'd4
    } kind_e;

    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic din;
    } pins_t;

    function automatic kind_e classify(input logic [ADDR_W-1:0] a);
        case (a[ADDR_W-1 -: 2])
            2'b00:   return K_W0;
            2'b01:   return K_W8;
            2'b10:   return K_W16;
            default: return a[0] ? K_R16 : K_R8;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] bits_needed(input kind_e k);
        case (k)
            K_W8:    return CNT_W'(ADDR_W + 8);
            K_W16:   return CNT_W'(ADDR_W + 16);
            default: return CNT_W'(ADDR_W);
        endcase
    endfunction

    function automatic logic is_write(input kind_e k);
        return (k == K_W0) || (k == K_W8) || (k == K_W16);
    endfunction

endpackage

// File: rtl/sbus_sync.sv
`timescale 1ns/1ps
module sbus_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[i] <= RST_VAL[i];
                sync_q[i] <= RST_VAL[i];
                prev_q[i] <= RST_VAL[i];
            end else begin
                meta_q[i] <= async_i[i];
                sync_q[i] <= meta_q[i];
                prev_q[i] <= sync_q[i];
            end
        end
        assign rise_o[i] = sync_q[i] & ~prev_q[i];
        assign fall_o[i] = ~sync_q[i] & prev_q[i];
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/sbus_rx.sv
`timescale 1ns/1ps
module sbus_rx
    import sbus_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_s,
    input  logic          cs_rise,
    input  logic          sclk_rise,
    input  logic          din_s,
    output logic          wr_o,
    output logic          rd_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output kind_e         kind_o
);
    localparam int SH_W = AW + DW;

    logic [CNT_W-1:0] cnt_q;
    logic [SH_W-1:0]  sh_q;
    logic             have_cmd_q;
    kind_e            kind_q;
    logic [CNT_W-1:0] limit;
    logic [AW-1:0]    next_addr;
    kind_e            next_kind;

    assign limit     = have_cmd_q ? bits_needed(kind_q) : CNT_W'(AW);
    assign next_addr = {sh_q[AW-2:0], din_s};
    assign next_kind = classify(next_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            sh_q       <= '0;
            have_cmd_q <= 1'b0;
            kind_q     <= K_W0;
            wr_o       <= 1'b0;
            rd_o       <= 1'b0;
            addr_o     <= '0;
            wdata_o    <= '0;
        end else begin
            wr_o <= 1'b0;
            rd_o <= 1'b0;
            if (cs_s) begin
                cnt_q      <= '0;
                have_cmd_q <= 1'b0;
                if (cs_rise && have_cmd_q && is_write(kind_q)
                    && cnt_q == bits_needed(kind_q)) begin
                    wr_o <= 1'b1;
                    case (kind_q)
                        K_W8:    wdata_o <= {{(DW-8){1'b0}}, sh_q[7:0]};
                        K_W16:   wdata_o <= sh_q[DW-1:0];
                        default: wdata_o <= '0;
                    endcase
                end
            end else if (sclk_rise && cnt_q < limit) begin
                sh_q  <= {sh_q[SH_W-2:0], din_s};
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_W'(AW - 1)) begin
                    addr_o     <= next_addr;
                    kind_q     <= next_kind;
                    have_cmd_q <= 1'b1;
                    rd_o       <= ~is_write(next_kind);
                end
            end
        end
    end

    assign kind_o = kind_q;

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(SH_W));

    assert_wr_single_R2: assert property (@(posedge clk) disable iff (rst)
        wr_o |=> !wr_o);

    assert_wr_rd_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(wr_o && rd_o));

endmodule

// File: rtl/sbus_tx.sv
`timescale 1ns/1ps
module sbus_tx
    import sbus_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_s,
    input  logic          sclk_fall,
    input  logic          load_i,
    input  kind_e         kind_i,
    input  logic [DW-1:0] rdata_i,
    output logic          reply_o,
    output logic          oe_o
);
    logic [DW-1:0] tx_q;
    logic          active_q;
    logic          seen_low_q;

    always_ff @(posedge clk) begin
        if (rst || cs_s) begin
            tx_q       <= '0;
            active_q   <= 1'b0;
            seen_low_q <= 1'b0;
            reply_o    <= 1'b0;
            oe_o       <= 1'b0;
        end else begin
            oe_o <= seen_low_q;
            if (load_i) begin
                tx_q     <= (kind_i == K_R16) ? rdata_i : {rdata_i[7:0], {(DW-8){1'b0}}};
                active_q <= 1'b1;
            end else if (sclk_fall) begin
                seen_low_q <= 1'b1;
                if (active_q) begin
                    reply_o <= tx_q[DW-1];
                    tx_q    <= {tx_q[DW-2:0], 1'b0};
                end
            end
        end
    end

    assert_oe_off_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_s) |=> !oe_o);

    assert_reply_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(reply_o) |-> ($past(sclk_fall) || $past(cs_s)));

endmodule

// File: rtl/sbus_periph.sv
`timescale 1ns/1ps
module sbus_periph
    import sbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              cmd_i,
    output logic              reply_o,
    output logic              reply_oe_o,
    output logic              reg_wr_o,
    output logic              reg_rd_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    input  logic [DATA_W-1:0] reg_rdata_i
);
    pins_t raw, syn, rise, fall;
    kind_e kind;

    assign raw = '{cs_n: cs_n_i, sclk: sclk_i, din: cmd_i};

    sbus_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw),
        .sync_o  (syn),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    sbus_rx #(.AW(ADDR_W), .DW(DATA_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .cs_s      (syn.cs_n),
        .cs_rise   (rise.cs_n),
        .sclk_rise (rise.sclk),
        .din_s     (syn.din),
        .wr_o      (reg_wr_o),
        .rd_o      (reg_rd_o),
        .addr_o    (reg_addr_o),
        .wdata_o   (reg_wdata_o),
        .kind_o    (kind)
    );

    sbus_tx #(.DW(DATA_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .cs_s      (syn.cs_n),
        .sclk_fall (fall.sclk),
        .load_i    (reg_rd_o),
        .kind_i    (kind),
        .rdata_i   (reg_rdata_i),
        .reply_o   (reply_o),
        .oe_o      (reply_oe_o)
    );

    assert_wr_after_release_R2: assert property (@(posedge clk) disable iff (rst)
        reg_wr_o |-> syn.cs_n);

    assert_rd_in_txn_R8: assert property (@(posedge clk) disable iff (rst)
        reg_rd_o |-> !syn.cs_n);

endmodule

// File: tb/sbus_periph_bench.sv
`timescale 1ns/1ps
module sbus_periph_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic        reply, reply_oe, reg_wr, reg_rd;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    int wr_cnt   = 0;
    int rd_cnt   = 0;
    logic [7:0]  last_addr = '0;
    logic [15:0] last_data = '0;

    always #2.5 clk = ~clk;

    assign reg_rdata = {reg_addr, ~reg_addr};

    sbus_periph u_sbus_periph (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .cmd_i(din),
        .reply_o(reply), .reply_oe_o(reply_oe), .reg_wr_o(reg_wr), .reg_rd_o(reg_rd),
        .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata)
    );

    always @(negedge clk) begin
        if (!rst && reg_wr) begin
            wr_cnt++;
            last_addr = reg_addr;
            last_data = reg_wdata;
        end
        if (!rst && reg_rd) rd_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic xfer(input bit idle_hi, input logic [23:0] bits, input int n,
                        input bit release_cs, output logic [15:0] got);
        got  = '0;
        sclk = idle_hi;
        #100;
        cs_n = 1'b0;
        #150;
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0;
            din  = bits[23-i];
            #200;
            if (i >= 8) got = {got[14:0], reply};
            sclk = 1'b1;
            #200;
        end
        if (!idle_hi) sclk = 1'b0;
        #150;
        if (release_cs) begin
            cs_n = 1'b1;
            #1200;
        end
    endtask

    task automatic t_reset();
        chk("R10 wr", reg_wr, 0);
        chk("R10 rd", reg_rd, 0);
        chk("R10 reply", reply, 0);
        chk("R10 oe", reply_oe, 0);
    endtask

    task automatic t_write16(input bit pol);
        logic [15:0] g;
        int w0 = wr_cnt;
        xfer(pol, {8'h93, 16'hA5C3}, 24, 1, g);
        chk("R1/R6 w16 count", wr_cnt - w0, 1);
        chk("R1/R6 w16 addr", last_addr, 8'h93);
        chk("R1/R6 w16 data", last_data, 16'hA5C3);
    endtask

    task automatic t_write8(input bit pol);
        logic [15:0] g;
        int w0 = wr_cnt;
        xfer(pol, {8'h4A, 8'h8E, 8'h00}, 16, 1, g);
        chk("R3/R6 w8 count", wr_cnt - w0, 1);
        chk("R3 w8 addr", last_addr, 8'h4A);
        chk("R3 w8 data", last_data, 16'h008E);
    endtask

    task automatic t_write0();
        logic [15:0] g;
        int w0 = wr_cnt;
        xfer(1'b0, {8'h05, 16'h0}, 8, 1, g);
        chk("R3 w0 count", wr_cnt - w0, 1);
        chk("R3 w0 addr", last_addr, 8'h05);
        chk("R3 w0 data", last_data, 16'h0000);
    endtask

    task automatic t_commit_at_release();
        logic [15:0] g;
        int w0 = wr_cnt;
        xfer(1'b1, {8'h82, 16'h1234}, 24, 0, g);
        #500;
        chk("R2 no strobe while selected", wr_cnt - w0, 0);
        cs_n = 1'b1;
        #1200;
        chk("R2 strobe after release", wr_cnt - w0, 1);
        chk("R2 data", last_data, 16'h1234);
    endtask

    task automatic t_short();
        logic [15:0] g;
        int w0 = wr_cnt;
        xfer(1'b0, {8'h91, 16'hFFFF}, 20, 1, g);
        chk("R4 short w16 discarded", wr_cnt - w0, 0);
        xfer(1'b1, {8'h41, 16'hFFFF}, 12, 1, g);
        chk("R4 short w8 discarded", wr_cnt - w0, 0);
    endtask

    task automatic t_extra();
        logic [15:0] g;
        int w0 = wr_cnt;
        xfer(1'b0, {8'h47, 8'h3C, 8'hFF}, 24, 1, g);
        chk("R9 extra bits count", wr_cnt - w0, 1);
        chk("R9 extra bits data", last_data, 16'h003C);
    endtask

    task automatic t_read(input bit pol);
        logic [15:0] g;
        int w0 = wr_cnt;
        int r0 = rd_cnt;
        xfer(pol, {8'hC1, 16'h0}, 24, 1, g);
        chk("R5/R6 r16 data", g, 16'hC13E);
        chk("R8 r16 rd pulses", rd_cnt - r0, 1);
        xfer(pol, {8'hC0, 16'h0}, 16, 1, g);
        chk("R5/R6 r8 data", g[7:0], 8'h3F);
        chk("R8 rd pulses", rd_cnt - r0, 2);
        chk("R8 no write", wr_cnt - w0, 0);
    endtask

    task automatic t_oe();
        sclk = 1'b1;
        #100;
        cs_n = 1'b0;
        #300;
        chk("R7 oe before first low", reply_oe, 0);
        sclk = 1'b0;
        #200;
        chk("R7 oe after low phase", reply_oe, 1);
        sclk = 1'b1;
        #200;
        cs_n = 1'b1;
        #100;
        chk("R7 oe after release", reply_oe, 0);
        #1200;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        #20;
        t_reset();
        t_write16(1'b0);
        t_write16(1'b1);
        t_write8(1'b0);
        t_write8(1'b1);
        t_write0();
        t_commit_at_release();
        t_short();
        t_extra();
        t_read(1'b0);
        t_read(1'b1);
        t_oe();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #500000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule